// File: doc/BRIEF.md
# AAL2 CPS Packet Cell Packer

This block fills outgoing cell buffers for a single AAL2 channel. Each buffer is 52 bytes long. The first four bytes are the channel's stored cell header. Byte 4 carries a one-byte start field. The remaining 47 bytes are filled with CPS packets. Every packet enters the block as a descriptor (channel identifier, user-to-user field, length indicator) followed by its payload bytes. The block emits a 3-byte packet header protected by a 5-bit CRC and then streams the payload into the buffer. It writes one byte per cycle through a simple write port.

A packet that does not fit in the current payload is held in the block's resume state. Its remaining bytes are placed at the front of the next buffer, and the start field of that buffer says how many continuation bytes come before the next packet header. When the queue runs dry between packets, a per-channel delay limit bounds how long the partly filled buffer may wait. On expiry, the unused bytes are zero-filled and the buffer is released. A transmit side tells the link whether a finished buffer is available or whether an idle cell must go out instead.

Top module: `aal2_cell_packer`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, buf_we_o, buf_rdy_o, hdr_ready_o, pay_ready_o, pkt_done_o, tx_cell_o and tx_idle_o are all 0.
- R2: The buffer layout is as follows. A buffer opens only when buf_avail_i is high while no buffer is open. Bytes 0..3 are ctx_cell_hdr_i, most significant byte at address 0. Address 4 is the start field. Addresses 5..51 are payload. buf_avail_i has no effect while a buffer is open.
- R3: The start field is {offset[5:0], sn, p}. sn is 0 for the first buffer after reset and toggles for each later buffer. p makes the byte's count of ones odd.
- R4: The start field offset is 0 when no packet is in progress as the buffer opens. Otherwise it is the number of bytes of the in-progress packet still to be placed, capped at 47.
- R5: The packet header is three bytes. The first is the CID. The second is {li[5:0], uui[4:3]}. The third is {uui[2:0], hec[4:0]}. li is the payload length minus one, taken from hdr_li_i. The header bytes are followed by li+1 payload bytes taken in order from pay_data_i.
- R6: hec is the remainder of {cid, li, uui} (19 bits, most significant first) multiplied by x^5 and divided by x^5+x^2+1.
- R7: Packet bytes, header bytes included, continue across buffer boundaries in order with none lost or repeated.
- R8: pkt_done_o pulses once per packet, in the cycle its last byte is written.
- R9: buf_rdy_o is a one-cycle pulse that follows the write of address 51. The cycle after it has no write.
- R10: If no packet is in progress and none is offered, the first zero fill byte is written ctx_max_dly_i+2 cycles after the start field write. The rest of the buffer is zero and then released. The limit never cuts a packet in progress, even while its payload stalls.
- R11: When tx_req_i is high and a released buffer is pending, tx_cell_o pulses and the pending flag clears. When tx_req_i is high with nothing pending, tx_idle_o pulses instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_avail_i | input | 1 | An empty buffer may be opened |
| ctx_cell_hdr_i | input | 32 | Channel cell header |
| ctx_max_dly_i | input | DLY_W | Partial buffer delay limit in cycles |
| hdr_valid_i | input | 1 | Packet descriptor valid |
| hdr_ready_o | output | 1 | Packet descriptor accepted |
| hdr_cid_i | input | 8 | Channel identifier |
| hdr_uui_i | input | 5 | User-to-user field |
| hdr_li_i | input | 6 | Payload length minus one |
| pay_valid_i | input | 1 | Payload byte valid |
| pay_ready_o | output | 1 | Payload byte accepted |
| pay_data_i | input | 8 | Payload byte |
| pkt_done_o | output | 1 | Packet fully placed, descriptor released |
| buf_we_o | output | 1 | Buffer byte write |
| buf_addr_o | output | 6 | Buffer byte address |
| buf_wdata_o | output | 8 | Buffer byte data |
| buf_rdy_o | output | 1 | Buffer complete and released |
| tx_req_i | input | 1 | Link wants a cell now |
| tx_cell_o | output | 1 | Released buffer is sent |
| tx_idle_o | output | 1 | Idle cell is sent |

## Verification
The bench builds the block with DLY_W set to 8. That is wide enough for the delay limits it drives: 0, 2, 5 and 40. A limit of 0 exercises the earliest possible flush. A limit of 2, combined with a payload source that is valid only one cycle in three, shows that a packet in progress is never cut short. The packet table is chosen to produce a packet whose remainder exceeds a full payload, which exercises the offset cap of 47. It also produces a packet header split across two buffers and a last buffer that needs zero fill. Two full table passes carry the sequence bit across fourteen buffers.

// File: rtl/aal2_pack_pkg.sv
`timescale 1ns/1ps
package aal2_pack_pkg;
  localparam int unsigned CELL_HDR_LEN = 4;
  localparam int unsigned PDU_LEN      = 48;
  localparam int unsigned BUF_LEN      = CELL_HDR_LEN + PDU_LEN;
  localparam int unsigned BUF_AW       = $clog2(BUF_LEN + 1);
  localparam int unsigned OFS_MAX      = PDU_LEN - 1;
  localparam int unsigned CPS_HDR_LEN  = 3;
  localparam int unsigned CID_W        = 8;
  localparam int unsigned LI_W         = 6;
  localparam int unsigned UUI_W        = 5;
  localparam int unsigned HEC_W        = 5;
  localparam int unsigned OFS_W        = 6;
  localparam int unsigned POS_W        = LI_W + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_STF, S_FILL, S_PAD
  } fill_st_e;

  // serial CRC, generator x^5+x^2+1, zero preset
  function automatic logic [HEC_W-1:0] cps_hec(input logic [CID_W+LI_W+UUI_W-1:0] d);
    logic [HEC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = CID_W + LI_W + UUI_W - 1; i >= 0; i--) begin
      fb = c[HEC_W-1] ^ d[i];
      c  = {c[HEC_W-2:0], 1'b0};
      if (fb) c = c ^ 5'b00101;
    end
    return c;
  endfunction

  function automatic logic [7:0] stf_byte(input logic [OFS_W-1:0] ofs, input logic sn);
    return {ofs, sn, ~^{ofs, sn}};
  endfunction
endpackage

// File: rtl/aal2_hdr_gen.sv
`timescale 1ns/1ps
module aal2_hdr_gen
  import aal2_pack_pkg::*;
(
  input  logic [CID_W-1:0] cid_i,
  input  logic [LI_W-1:0]  li_i,
  input  logic [UUI_W-1:0] uui_i,
  output logic [2:0][7:0]  hdr_o
);
  logic [HEC_W-1:0] hec;

  always_comb begin
    hec      = cps_hec({cid_i, li_i, uui_i});
    hdr_o[0] = cid_i;
    hdr_o[1] = {li_i, uui_i[4:3]};
    hdr_o[2] = {uui_i[2:0], hec};
  end
endmodule

// File: rtl/aal2_stf_gen.sv
`timescale 1ns/1ps
module aal2_stf_gen
  import aal2_pack_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [7:0]       stf_o
);
  logic sn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sn_q <= 1'b0;
    else if (adv_i) sn_q <= ~sn_q;
  end

  assign stf_o = stf_byte(ofs_i, sn_q);
endmodule

// File: rtl/aal2_dly_timer.sv
`timescale 1ns/1ps
module aal2_dly_timer #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DLY_W-1:0] lim_i,
  output logic             exp_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (run_i && cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
  end

  assign exp_o = cnt_q >= lim_i;
endmodule

// File: rtl/aal2_tx_gate.sv
`timescale 1ns/1ps
module aal2_tx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic buf_rdy_i,
  input  logic tx_req_i,
  output logic tx_cell_o,
  output logic tx_idle_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= buf_rdy_i | (pend_q & ~tx_req_i);
  end

  assign tx_cell_o = tx_req_i &  pend_q;
  assign tx_idle_o = tx_req_i & ~pend_q;
endmodule

// File: rtl/aal2_cell_packer.sv
`timescale 1ns/1ps
module aal2_cell_packer
  import aal2_pack_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             buf_avail_i,
  input  logic [31:0]      ctx_cell_hdr_i,
  input  logic [DLY_W-1:0] ctx_max_dly_i,
  input  logic             hdr_valid_i,
  output logic             hdr_ready_o,
  input  logic [7:0]       hdr_cid_i,
  input  logic [4:0]       hdr_uui_i,
  input  logic [5:0]       hdr_li_i,
  input  logic             pay_valid_i,
  output logic             pay_ready_o,
  input  logic [7:0]       pay_data_i,
  output logic             pkt_done_o,
  output logic             buf_we_o,
  output logic [5:0]       buf_addr_o,
  output logic [7:0]       buf_wdata_o,
  output logic             buf_rdy_o,
  input  logic             tx_req_i,
  output logic             tx_cell_o,
  output logic             tx_idle_o
);
  localparam logic [BUF_AW-1:0] ADDR_FULL = BUF_AW'(BUF_LEN);
  localparam logic [BUF_AW-1:0] ADDR_HLST = BUF_AW'(CELL_HDR_LEN - 1);
  localparam logic [POS_W-1:0]  POS_HDR   = POS_W'(CPS_HDR_LEN);
  localparam logic [POS_W-1:0]  REM_CAP   = POS_W'(OFS_MAX);

  fill_st_e          st_q, st_d;
  logic [BUF_AW-1:0] addr_q, addr_d;
  logic              act_q, act_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [CID_W-1:0]  cid_q;
  logic [UUI_W-1:0]  uui_q;
  logic [LI_W-1:0]   li_q;
  logic              latch;

  logic [2:0][7:0]   cps_hdr;
  logic [7:0]        stf;
  logic [OFS_W-1:0]  ofs;
  logic [POS_W-1:0]  pkt_tot, rem, pos_last;
  logic              tmr_exp, full;
  logic [1:0]        hsel;

  aal2_hdr_gen u_hdr (
    .cid_i (cid_q),
    .li_i  (li_q),
    .uui_i (uui_q),
    .hdr_o (cps_hdr)
  );

  aal2_stf_gen u_stf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (st_q == S_STF),
    .ofs_i  (ofs),
    .stf_o  (stf)
  );

  aal2_dly_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q == S_STF),
    .run_i  (st_q == S_FILL),
    .lim_i  (ctx_max_dly_i),
    .exp_o  (tmr_exp)
  );

  aal2_tx_gate u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .buf_rdy_i (buf_rdy_o),
    .tx_req_i  (tx_req_i),
    .tx_cell_o (tx_cell_o),
    .tx_idle_o (tx_idle_o)
  );

  // bytes of the packet in progress still to be written
  always_comb begin
    pkt_tot  = {1'b0, li_q} + POS_W'(CPS_HDR_LEN + 1);
    pos_last = pkt_tot - 1'b1;
    rem      = pkt_tot - pos_q;
    if (!act_q)              ofs = '0;
    else if (rem > REM_CAP)  ofs = OFS_W'(OFS_MAX);
    else                     ofs = rem[OFS_W-1:0];
  end

  assign full = (addr_q == ADDR_FULL);
  assign hsel = 2'd3 - addr_q[1:0];

  always_comb begin
    st_d        = st_q;
    addr_d      = addr_q;
    act_d       = act_q;
    pos_d       = pos_q;
    latch       = 1'b0;
    buf_we_o    = 1'b0;
    buf_wdata_o = '0;
    buf_rdy_o   = 1'b0;
    hdr_ready_o = 1'b0;
    pay_ready_o = 1'b0;
    pkt_done_o  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (buf_avail_i) begin
          st_d   = S_HDR;
          addr_d = '0;
        end
      end
      S_HDR: begin
        buf_we_o    = 1'b1;
        buf_wdata_o = ctx_cell_hdr_i[{hsel, 3'b000} +: 8];
        addr_d      = addr_q + 1'b1;
        if (addr_q == ADDR_HLST) st_d = S_STF;
      end
      S_STF: begin
        buf_we_o    = 1'b1;
        buf_wdata_o = stf;
        addr_d      = addr_q + 1'b1;
        st_d        = S_FILL;
      end
      S_FILL: begin
        if (full) begin
          buf_rdy_o = 1'b1;
          st_d      = S_IDLE;
        end else if (act_q) begin
          pay_ready_o = (pos_q >= POS_HDR);
          if (pos_q < POS_HDR || pay_valid_i) begin
            buf_we_o    = 1'b1;
            buf_wdata_o = (pos_q < POS_HDR) ? cps_hdr[pos_q[1:0]] : pay_data_i;
            addr_d      = addr_q + 1'b1;
            pos_d       = pos_q + 1'b1;
            if (pos_q == pos_last) begin
              act_d      = 1'b0;
              pkt_done_o = 1'b1;
            end
          end
        end else if (hdr_valid_i) begin
          hdr_ready_o = 1'b1;
          latch       = 1'b1;
          act_d       = 1'b1;
          pos_d       = '0;
        end else if (tmr_exp) begin
          st_d = S_PAD;
        end
      end
      S_PAD: begin
        if (full) begin
          buf_rdy_o = 1'b1;
          st_d      = S_IDLE;
        end else begin
          buf_we_o = 1'b1;
          addr_d   = addr_q + 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign buf_addr_o = addr_q[5:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      act_q  <= 1'b0;
      pos_q  <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      act_q  <= act_d;
      pos_q  <= pos_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cid_q <= '0;
      uui_q <= '0;
      li_q  <= '0;
    end else if (latch) begin
      cid_q <= hdr_cid_i;
      uui_q <= hdr_uui_i;
      li_q  <= hdr_li_i;
    end
  end
endmodule

// File: rtl/aal2_cell_packer_chk.sv
`timescale 1ns/1ps
module aal2_cell_packer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       buf_we_o,
  input logic [5:0] buf_addr_o,
  input logic [7:0] buf_wdata_o,
  input logic       buf_rdy_o,
  input logic       pkt_done_o,
  input logic       hdr_ready_o,
  input logic       pay_ready_o,
  input logic       tx_req_i,
  input logic       tx_cell_o,
  input logic       tx_idle_o
);
  logic [5:0] last_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_wr_q <= '0;
    else if (buf_we_o) last_wr_q <= buf_addr_o;
  end

  p_wr_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> buf_addr_o < 6'd52);

  p_stf_odd_parity_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_o && buf_addr_o == 6'd4) |-> (^buf_wdata_o));

  p_one_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdr_ready_o && pay_ready_o));

  p_done_on_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> buf_we_o);

  p_rdy_after_last_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rdy_o |-> (last_wr_q == 6'd51 && !buf_we_o));

  p_rdy_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rdy_o |=> (!buf_we_o && !buf_rdy_o));

  p_tx_answer_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_i |-> $countones({tx_cell_o, tx_idle_o}) == 1);

  p_tx_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_req_i |-> !(tx_cell_o || tx_idle_o));
endmodule

bind aal2_cell_packer aal2_cell_packer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .buf_we_o    (buf_we_o),
  .buf_addr_o  (buf_addr_o),
  .buf_wdata_o (buf_wdata_o),
  .buf_rdy_o   (buf_rdy_o),
  .pkt_done_o  (pkt_done_o),
  .hdr_ready_o (hdr_ready_o),
  .pay_ready_o (pay_ready_o),
  .tx_req_i    (tx_req_i),
  .tx_cell_o   (tx_cell_o),
  .tx_idle_o   (tx_idle_o)
);

// File: tb/aal2_cell_packer_tb_top.sv
`timescale 1ns/1ps
module aal2_cell_packer_tb_top;
  localparam int DLY_W = 8;
  localparam int NPK   = 8;
  // {cid, uui, li}
  localparam logic [18:0] PKT_TBL [NPK] = '{
    {8'h11, 5'd3,  6'd36},
    {8'h22, 5'd17, 6'd63},
    {8'h33, 5'd0,  6'd0 },
    {8'h44, 5'd31, 6'd40},
    {8'h55, 5'd8,  6'd43},
    {8'h66, 5'd21, 6'd20},
    {8'h77, 5'd5,  6'd3 },
    {8'hC8, 5'd30, 6'd31}
  };

  logic clk = 1'b0;
  logic rst_ni;
  logic buf_avail_i;
  logic [31:0] ctx_cell_hdr_i;
  logic [DLY_W-1:0] ctx_max_dly_i;
  logic hdr_valid_i, hdr_ready_o;
  logic [7:0] hdr_cid_i;
  logic [4:0] hdr_uui_i;
  logic [5:0] hdr_li_i;
  logic pay_valid_i, pay_ready_o;
  logic [7:0] pay_data_i;
  logic pkt_done_o, buf_we_o, buf_rdy_o;
  logic [5:0] buf_addr_o;
  logic [7:0] buf_wdata_o;
  logic tx_req_i, tx_cell_o, tx_idle_o;

  always #2.5 clk = ~clk;

  aal2_cell_packer #(.DLY_W(DLY_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .buf_avail_i(buf_avail_i),
    .ctx_cell_hdr_i(ctx_cell_hdr_i), .ctx_max_dly_i(ctx_max_dly_i),
    .hdr_valid_i(hdr_valid_i), .hdr_ready_o(hdr_ready_o),
    .hdr_cid_i(hdr_cid_i), .hdr_uui_i(hdr_uui_i), .hdr_li_i(hdr_li_i),
    .pay_valid_i(pay_valid_i), .pay_ready_o(pay_ready_o), .pay_data_i(pay_data_i),
    .pkt_done_o(pkt_done_o), .buf_we_o(buf_we_o), .buf_addr_o(buf_addr_o),
    .buf_wdata_o(buf_wdata_o), .buf_rdy_o(buf_rdy_o),
    .tx_req_i(tx_req_i), .tx_cell_o(tx_cell_o), .tx_idle_o(tx_idle_o)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model storage
  logic [7:0] sb [300];
  bit         sstart [300];
  int         send [300];
  int         s_total;
  logic [7:0] pf [600];
  int         npay;
  logic [7:0] exp_mem [16][52];
  int         exp_cnt = 0;

  function automatic logic [4:0] ref_hec(input logic [18:0] d);
    logic [23:0] r;
    r = {d, 5'b0};
    for (int i = 23; i >= 5; i--)
      if (r[i]) r = r ^ (24'b100101 << (i - 5));
    return r[4:0];
  endfunction

  function automatic logic [7:0] pat(input int p, input int b);
    return 8'((p * 37 + b * 5 + 1) & 255);
  endfunction

  task automatic build_stream();
    s_total = 0;
    npay = 0;
    for (int p = 0; p < NPK; p++) begin
      logic [7:0] cid; logic [4:0] uui; logic [5:0] li; int st;
      {cid, uui, li} = PKT_TBL[p];
      st = s_total;
      sb[s_total] = cid;                            sstart[s_total] = 1'b1;
      sb[s_total+1] = {li, uui[4:3]};               sstart[s_total+1] = 1'b0;
      sb[s_total+2] = {uui[2:0], ref_hec({cid, li, uui})}; sstart[s_total+2] = 1'b0;
      s_total += 3;
      for (int b = 0; b <= int'(li); b++) begin
        sb[s_total] = pat(p, b);
        sstart[s_total] = 1'b0;
        pf[npay] = pat(p, b);
        npay++;
        s_total++;
      end
      for (int k = st; k < s_total; k++) send[k] = s_total;
    end
  endtask

  // one expected buffer whose payload starts at stream position s
  task automatic add_cell(input int s, input int total, input logic [31:0] ch);
    int ofs;
    logic sn;
    for (int i = 0; i < 4; i++) exp_mem[exp_cnt][i] = ch[31-8*i -: 8];
    if (s >= total || sstart[s]) ofs = 0;
    else ofs = (send[s] - s > 47) ? 47 : send[s] - s;
    sn = exp_cnt[0];
    exp_mem[exp_cnt][4] = {6'(ofs), sn, ~^{6'(ofs), sn}};
    for (int j = 0; j < 47; j++)
      exp_mem[exp_cnt][5+j] = (s + j < total) ? sb[s+j] : 8'h00;
    exp_cnt++;
  endtask

  // monitor
  logic [7:0] cap [52];
  int cells_done = 0;
  int done_cnt = 0;
  int cyc = 0;
  int stf_cyc = 0, w5_cyc = 0, a0_cnt = 0;
  int last_gap = 0, last_a0 = 0;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_ni) begin
        if (pkt_done_o) done_cnt++;
        if (buf_we_o && buf_addr_o < 6'd52) begin
          cap[buf_addr_o] = buf_wdata_o;
          if (buf_addr_o == 6'd0) a0_cnt++;
          if (buf_addr_o == 6'd4) stf_cyc = cyc;
          if (buf_addr_o == 6'd5) w5_cyc = cyc;
        end
        if (buf_rdy_o) begin
          int bad;
          bad = -1;
          if (cells_done < exp_cnt) begin
            for (int i = 51; i >= 0; i--)
              if (cap[i] !== exp_mem[cells_done][i]) bad = i;
            if (bad >= 0)
              chk(1'b0, "R2 R3 R4 R5 R6 R7 R10", $sformatf("buffer %0d byte %0d", cells_done, bad),
                  longint'(cap[bad]), longint'(exp_mem[cells_done][bad]));
            else
              chk(1'b1, "R2", "buffer", 0, 0);
          end else begin
            chk(1'b0, "R9", "unexpected buffer release", cells_done, exp_cnt);
          end
          last_gap = w5_cyc - stf_cyc;
          last_a0 = a0_cnt;
          a0_cnt = 0;
          cells_done++;
        end
      end
    end
  end

  // packet source
  bit feed_en = 1'b0;
  bit gate_slow = 1'b0;
  int hi = 0, pi = 0;

  initial begin
    bit ht, pt;
    int fc;
    fc = 0;
    hdr_valid_i = 1'b0; hdr_cid_i = '0; hdr_uui_i = '0; hdr_li_i = '0;
    pay_valid_i = 1'b0; pay_data_i = '0;
    forever begin
      @(negedge clk);
      ht = hdr_valid_i && hdr_ready_o;
      pt = pay_valid_i && pay_ready_o;
      @(posedge clk);
      #1;
      fc++;
      if (!feed_en) begin
        hi = 0;
        pi = 0;
      end else begin
        if (ht) hi++;
        if (pt) pi++;
      end
      hdr_valid_i = feed_en && hi < NPK;
      if (hi < NPK) {hdr_cid_i, hdr_uui_i, hdr_li_i} = PKT_TBL[hi];
      pay_valid_i = feed_en && pi < npay && (!gate_slow || fc % 3 == 0);
      pay_data_i  = (pi < npay) ? pf[pi] : 8'h00;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  task automatic pulse_avail();
    @(posedge clk); #1 buf_avail_i = 1'b1;
    @(posedge clk); #1 buf_avail_i = 1'b0;
  endtask

  task automatic run_stream(input int dly, input bit slow);
    int base, d0;
    feed_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    ctx_max_dly_i = DLY_W'(dly);
    gate_slow = slow;
    base = exp_cnt;
    for (int s = 0; s < s_total; s += 47) add_cell(s, s_total, ctx_cell_hdr_i);
    d0 = done_cnt;
    feed_en = 1'b1;
    for (int c = base; c < exp_cnt; c++) begin
      pulse_avail();
      wait (cells_done == c + 1);
    end
    @(negedge clk);
    chk(done_cnt - d0 == NPK, "R8", "packets released", done_cnt - d0, NPK);
    chk(pi == npay, "R7", "payload bytes consumed", pi, npay);
  endtask

  initial begin
    rst_ni = 1'b0;
    buf_avail_i = 1'b0;
    tx_req_i = 1'b0;
    ctx_cell_hdr_i = 32'h1234_56A0;
    ctx_max_dly_i = '0;
    build_stream();
    repeat (2) @(negedge clk);
    chk({buf_we_o, buf_rdy_o, hdr_ready_o, pay_ready_o, pkt_done_o, tx_cell_o, tx_idle_o} == 7'b0,
        "R1", "outputs in reset",
        {buf_we_o, buf_rdy_o, hdr_ready_o, pay_ready_o, pkt_done_o, tx_cell_o, tx_idle_o}, 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    @(negedge clk);
    chk({buf_we_o, buf_rdy_o, hdr_ready_o, pay_ready_o, pkt_done_o, tx_cell_o, tx_idle_o} == 7'b0,
        "R1", "outputs after reset",
        {buf_we_o, buf_rdy_o, hdr_ready_o, pay_ready_o, pkt_done_o, tx_cell_o, tx_idle_o}, 0);

    // nothing pending: idle cell
    @(posedge clk); #1 tx_req_i = 1'b1;
    @(negedge clk);
    chk(tx_idle_o && !tx_cell_o, "R11", "idle on empty", {tx_cell_o, tx_idle_o}, 1);
    @(posedge clk); #1 tx_req_i = 1'b0;

    // flush with limit 5, buf_avail_i held through the open buffer
    ctx_max_dly_i = 8'd5;
    add_cell(0, 0, ctx_cell_hdr_i);
    @(posedge clk); #1 buf_avail_i = 1'b1;
    wait (cells_done == 1);
    buf_avail_i = 1'b0;
    chk(last_gap == 7, "R10", "flush delay limit 5", last_gap, 7);
    chk(last_a0 == 1, "R2", "reopen while open", last_a0, 1);

    // flush with limit 0
    ctx_max_dly_i = 8'd0;
    ctx_cell_hdr_i = 32'hA5C3_0F81;
    add_cell(0, 0, ctx_cell_hdr_i);
    pulse_avail();
    wait (cells_done == 2);
    chk(last_gap == 2, "R10", "flush delay limit 0", last_gap, 2);

    // packet table, payload always valid
    ctx_cell_hdr_i = 32'h0BAD_F00D;
    run_stream(40, 1'b0);
    // same table, slow payload and short limit: no mid-packet flush
    ctx_cell_hdr_i = 32'h7E11_2233;
    run_stream(2, 1'b1);
    chk(cells_done == 14, "R9", "buffers released", cells_done, 14);

    // released buffer pending: cell, then idle
    @(posedge clk); #1 tx_req_i = 1'b1;
    @(negedge clk);
    chk(tx_cell_o && !tx_idle_o, "R11", "cell when pending", {tx_cell_o, tx_idle_o}, 2);
    @(posedge clk); #1;
    @(negedge clk);
    chk(tx_idle_o && !tx_cell_o, "R11", "idle after send", {tx_cell_o, tx_idle_o}, 1);
    @(posedge clk); #1 tx_req_i = 1'b0;

    repeat (2) @(posedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule